// File: doc/BRIEF.md
# Root Port Legacy Interrupt Queue and Control Registers

This block is the interrupt side of a PCIe root port bridge, seen from software as a handful of 32-bit configuration registers. Legacy INTx assert and deassert messages from downstream devices arrive on an event input. Each one is formatted into a queue entry that holds the lane, the assert level and a valid flag, and is stored in a small circular queue. Software reads the oldest entry through either of two queue read registers. It removes that entry by writing to either of them.

Alongside the queue sit four more registers. A decode register records pending interrupt causes, and software clears it by writing ones. A mask register selects which causes raise the single level-sensitive interrupt output. A PHY status register reports the link-up input. A root port status/control register holds a bridge enable, a live queue not-empty flag and a sticky overflow flag.

Register reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `rp_intq_regs`

## Requirements
- R1: After reset the decode, mask and root port status/control registers read zero, the queue is empty, and irq_o is low.
- R2: An accepted event forms queue word 1 with the lane in bits 28:27, the assert level in bit 29 and a valid flag of 1 in bit 31, with all other bits 0. Queue word 2 (offset 0x15C) reads 0 for every entry.
- R3: The queue holds at most DEPTH-1 entries and returns them oldest first. An event that arrives while the queue is full is dropped, leaves the stored entries unchanged, and sets the overflow bit (bit 19) of the status/control register at 0x148.
- R4: The overflow bit stays set until a write to 0x148 with bit 19 set. A write with bit 19 clear leaves it set.
- R5: An accepted event sets bit 16 (INTx received) of the decode register at 0x138. That bit cannot be cleared while the queue is non-empty, and it stays set after the queue empties until software clears it.
- R6: A write to the decode register clears every bit that is written as 1 and leaves the others unchanged.
- R7: A write to the mask register at 0x13C replaces it. irq_o equals the OR of (decode AND mask) and follows each update from the clock edge that makes it.
- R8: A read of 0x158 or 0x15C returns the head entry's word, or 0 when the queue is empty. A write to either address pops one entry. A write while the queue is empty has no effect.
- R9: The PHY register at 0x144 reads bit 11 equal to link_up, with all other bits 0.
- R10: Bit 0 of 0x148 is a read/write bridge enable. Bit 18 of 0x148 reads 1 exactly when the queue is non-empty.
- R11: When an event and a pop occur in the same cycle, both take effect. The full check uses the occupancy from before the pop, so at DEPTH-1 entries the event is dropped and the overflow bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Register byte address |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| link_up | input | 1 | Link status from the PHY |
| evt_valid | input | 1 | Interrupt message arrives this cycle |
| evt_lane | input | 2 | INTx lane of the message |
| evt_level | input | 1 | 1 for assert, 0 for deassert |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench fills the queue past its capacity. A design that allowed all DEPTH slots to be used, or that overwrote the head, would return the wrong count or a corrupted order when the queue is drained. It pairs a pop with an arriving event both at DEPTH-1 entries and at low occupancy. A design that took its full decision from the post-pop pointers would accept the event that should be dropped, and one that dropped either action would lose an entry. It writes the pop registers while the queue is empty. A design that moved its read pointer then would show a phantom not-empty flag or a non-zero read. It also tries to clear the INTx decode bit and the overflow flag at the wrong moments, which exposes a bit that falls while entries remain or a flag that clears without its write-one.

// File: rtl/rpq_pkg.sv
package rpq_pkg;

  // register byte offsets
  localparam int unsigned OFF_DECODE = 32'h138;
  localparam int unsigned OFF_MASK   = 32'h13C;
  localparam int unsigned OFF_PHY    = 32'h144;
  localparam int unsigned OFF_RPSC   = 32'h148;
  localparam int unsigned OFF_QW1    = 32'h158;
  localparam int unsigned OFF_QW2    = 32'h15C;

  // bit positions
  localparam int unsigned B_INTX   = 16;
  localparam int unsigned B_MSI    = 17;
  localparam int unsigned B_LINK   = 11;
  localparam int unsigned B_BREN   = 0;
  localparam int unsigned B_NEMPTY = 18;
  localparam int unsigned B_OVF    = 19;
  localparam int unsigned B_LANE   = 27;
  localparam int unsigned B_LEVEL  = 29;
  localparam int unsigned B_VALID  = 31;

  localparam int unsigned LANE_W = 2;

  typedef struct packed {
    logic [LANE_W-1:0] lane;
    logic              level;
  } evt_t;

  // formats one stored event as the word seen by software
  function automatic logic [31:0] fmt_word1(input evt_t e);
    logic [31:0] w;
    w = '0;
    w[B_LANE +: LANE_W] = e.lane;
    w[B_LEVEL]          = e.level;
    w[B_VALID]          = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/rpq_addr_dec.sv
module rpq_addr_dec #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              sel_decode,
  output logic              sel_mask,
  output logic              sel_phy,
  output logic              sel_rpsc,
  output logic              sel_qw1,
  output logic              sel_qw2,
  output logic              wr_decode,
  output logic              wr_mask,
  output logic              wr_rpsc,
  output logic              wr_pop
);
  import rpq_pkg::*;

  assign sel_decode = (addr == ADDR_W'(OFF_DECODE));
  assign sel_mask   = (addr == ADDR_W'(OFF_MASK));
  assign sel_phy    = (addr == ADDR_W'(OFF_PHY));
  assign sel_rpsc   = (addr == ADDR_W'(OFF_RPSC));
  assign sel_qw1    = (addr == ADDR_W'(OFF_QW1));
  assign sel_qw2    = (addr == ADDR_W'(OFF_QW2));

  assign wr_decode = we & sel_decode;
  assign wr_mask   = we & sel_mask;
  assign wr_rpsc   = we & sel_rpsc;
  assign wr_pop    = we & (sel_qw1 | sel_qw2);
endmodule

// File: rtl/rpq_fifo.sv
module rpq_fifo #(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  rpq_pkg::evt_t   push_data,
  input  logic            pop_req,
  output rpq_pkg::evt_t   head,
  output logic            empty,
  output logic            full,
  output logic            push_ok,
  output logic            drop,
  output logic            pop_ok,
  output logic            nonempty_next,
  output logic [PW-1:0]   wr_ptr,
  output logic [PW-1:0]   rd_ptr
);
  import rpq_pkg::*;

  // modulo-DEPTH pointer advance, correct for any depth
  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  evt_t          mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_n, rp_n;

  // full/empty from pointers before any pop this cycle
  assign empty   = (wp_q == rp_q);
  assign full    = (bump(wp_q) == rp_q);
  assign push_ok = push_req & ~full;
  assign drop    = push_req & full;
  assign pop_ok  = pop_req & ~empty;

  assign wp_n = push_ok ? bump(wp_q) : wp_q;
  assign rp_n = pop_ok  ? bump(rp_q) : rp_q;
  assign nonempty_next = (wp_n != rp_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  assign head   = mem[rp_q];
  assign wr_ptr = wp_q;
  assign rd_ptr = rp_q;
endmodule

// File: rtl/rpq_intc.sv
module rpq_intc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_decode,
  input  logic        wr_mask,
  input  logic [31:0] wdata,
  input  logic        set_intx,
  input  logic        hold_intx,
  output logic [31:0] decode_q,
  output logic [31:0] mask_q,
  output logic        irq
);
  import rpq_pkg::*;

  logic [31:0] decode_n;

  always_comb begin
    decode_n = decode_q;
    if (wr_decode) decode_n = decode_n & ~wdata;
    // a new entry, or any entry still queued, keeps INTx pending
    if (set_intx || hold_intx) decode_n[B_INTX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decode_q <= '0;
      mask_q   <= '0;
    end else begin
      decode_q <= decode_n;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign irq = |(decode_q & mask_q);
endmodule

// File: rtl/rp_intq_regs.sv
module rp_intq_regs #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              link_up,
  input  logic              evt_valid,
  input  logic [1:0]        evt_lane,
  input  logic              evt_level,
  output logic              irq_o
);
  import rpq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic sel_decode, sel_mask, sel_phy, sel_rpsc, sel_qw1, sel_qw2;
  logic wr_decode, wr_mask, wr_rpsc, wr_pop;

  rpq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(cfg_addr), .we(cfg_we),
    .sel_decode(sel_decode), .sel_mask(sel_mask), .sel_phy(sel_phy),
    .sel_rpsc(sel_rpsc), .sel_qw1(sel_qw1), .sel_qw2(sel_qw2),
    .wr_decode(wr_decode), .wr_mask(wr_mask), .wr_rpsc(wr_rpsc),
    .wr_pop(wr_pop)
  );

  evt_t          evt_in, head;
  logic          fifo_empty, fifo_full, push_ok, drop, pop_ok, nonempty_next;
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign evt_in.lane  = evt_lane;
  assign evt_in.level = evt_level;

  rpq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(evt_valid), .push_data(evt_in), .pop_req(wr_pop),
    .head(head), .empty(fifo_empty), .full(fifo_full),
    .push_ok(push_ok), .drop(drop), .pop_ok(pop_ok),
    .nonempty_next(nonempty_next), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  logic [31:0] decode_q, mask_q;

  rpq_intc u_intc (
    .clk(clk), .rst_n(rst_n),
    .wr_decode(wr_decode), .wr_mask(wr_mask), .wdata(cfg_wdata),
    .set_intx(push_ok), .hold_intx(nonempty_next),
    .decode_q(decode_q), .mask_q(mask_q), .irq(irq_o)
  );

  // root port status/control
  logic bren_q, ovf_q, ovf_clr;
  assign ovf_clr = wr_rpsc & cfg_wdata[B_OVF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bren_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_rpsc) bren_q <= cfg_wdata[B_BREN];
      ovf_q <= drop | (ovf_q & ~ovf_clr);
    end
  end

  logic [31:0] rpsc_rd, phy_rd, qw1_rd;

  always_comb begin
    rpsc_rd = '0;
    rpsc_rd[B_BREN]   = bren_q;
    rpsc_rd[B_NEMPTY] = ~fifo_empty;
    rpsc_rd[B_OVF]    = ovf_q;
    phy_rd = '0;
    phy_rd[B_LINK] = link_up;
    qw1_rd = fifo_empty ? 32'h0 : fmt_word1(head);
  end

  always_comb begin
    cfg_rdata = '0;
    if (sel_decode) cfg_rdata = decode_q;
    if (sel_mask)   cfg_rdata = mask_q;
    if (sel_phy)    cfg_rdata = phy_rd;
    if (sel_rpsc)   cfg_rdata = rpsc_rd;
    if (sel_qw1)    cfg_rdata = qw1_rd;
    if (sel_qw2)    cfg_rdata = 32'h0;
  end

endmodule

// File: rtl/rpq_chk.sv
module rpq_chk #(
  parameter int ADDR_W = 12,
  parameter int PW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              link_up,
  input logic              irq_o,
  input logic              drop,
  input logic              push_ok,
  input logic              wr_pop,
  input logic              wr_mask,
  input logic              ovf_q,
  input logic              ovf_clr,
  input logic              fifo_empty,
  input logic [31:0]       decode_q,
  input logic [PW-1:0]     rd_ptr
);
  import rpq_pkg::*;

  p_drop_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  p_intx_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_empty |-> decode_q[B_INTX]);

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(push_ok || wr_mask));

  p_empty_pop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && wr_pop) |=> $stable(rd_ptr));

  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && (cfg_addr == ADDR_W'(OFF_QW1))) |-> (cfg_rdata == 32'h0));

  p_link_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(OFF_PHY)) |-> (cfg_rdata[B_LINK] == link_up));

endmodule

bind rp_intq_regs rpq_chk #(.ADDR_W(ADDR_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .link_up(link_up), .irq_o(irq_o), .drop(drop), .push_ok(push_ok),
  .wr_pop(wr_pop), .wr_mask(wr_mask), .ovf_q(ovf_q), .ovf_clr(ovf_clr),
  .fifo_empty(fifo_empty), .decode_q(decode_q), .rd_ptr(rd_ptr)
);

// File: tb/rp_intq_regs_test.sv
module rp_intq_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 16;

  localparam logic [11:0] A_DEC  = 12'h138;
  localparam logic [11:0] A_MASK = 12'h13C;
  localparam logic [11:0] A_PHY  = 12'h144;
  localparam logic [11:0] A_RPSC = 12'h148;
  localparam logic [11:0] A_QW1  = 12'h158;
  localparam logic [11:0] A_QW2  = 12'h15C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic link_up = 1'b0;
  logic evt_valid = 1'b0;
  logic [1:0] evt_lane = '0;
  logic evt_level = 1'b0;
  logic irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_q[$];
  logic exp_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_intq_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .link_up(link_up),
    .evt_valid(evt_valid), .evt_lane(evt_lane), .evt_level(evt_level),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [1:0] lane, input logic lvl);
    return 32'h8000_0000 | (32'(lvl) << 29) | (32'(lane) << 27);
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: sends one event and records what the queue should hold
  task automatic send(input logic [1:0] lane, input logic lvl, input logic with_pop);
    bit full_before;
    full_before = (exp_q.size() >= DEPTH - 1);
    @(negedge clk);
    evt_valid = 1'b1; evt_lane = lane; evt_level = lvl;
    if (with_pop) begin cfg_addr = A_QW1; cfg_we = 1'b1; end
    @(negedge clk);
    evt_valid = 1'b0; cfg_we = 1'b0;
    if (with_pop && exp_q.size() > 0) void'(exp_q.pop_front());
    if (full_before) exp_ovf = 1'b1;
    else exp_q.push_back(word_of(lane, lvl));
  endtask

  // monitor: drains the queue comparing each head with the scoreboard
  task automatic drain(input string req);
    logic [31:0] v;
    while (exp_q.size() > 0) begin
      rd(A_QW1, v);
      chk(req, v, exp_q.pop_front());
      wr(A_QW2, 32'h0);
    end
    rd(A_QW1, v);
    chk({req, " empty after drain"}, v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_DEC, v);  chk("R1 decode", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    rd(A_RPSC, v); chk("R1 rpsc", v, 0);
    rd(A_QW1, v);  chk("R1 qw1", v, 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R9 link bit
    rd(A_PHY, v); chk("R9 link down", v, 0);
    link_up = 1'b1;
    rd(A_PHY, v); chk("R9 link up", v, 32'h800);

    // R10 bridge enable
    wr(A_RPSC, 32'h1);
    rd(A_RPSC, v); chk("R10 bren set", v, 32'h1);

    // R7 mask replace
    wr(A_MASK, 32'h0001_0000);
    rd(A_MASK, v); chk("R7 mask", v, 32'h0001_0000);
    chk("R7 irq idle", 32'(irq_o), 0);

    // R2 / R5 one event
    send(2'd2, 1'b1, 1'b0);
    rd(A_QW1, v); chk("R2 word1", v, 32'hB000_0000);
    rd(A_QW2, v); chk("R2 word2", v, 0);
    rd(A_DEC, v); chk("R5 intx set", v, 32'h0001_0000);
    chk("R7 irq on", 32'(irq_o), 1);
    rd(A_RPSC, v); chk("R10 nonempty", v, 32'h0004_0001);

    // R5 cannot clear while queued, R6 clear after
    wr(A_DEC, 32'h0001_0000);
    rd(A_DEC, v); chk("R5 held", v, 32'h0001_0000);
    wr(A_QW2, 32'h0); void'(exp_q.pop_front());
    rd(A_DEC, v); chk("R5 stays after empty", v, 32'h0001_0000);
    rd(A_RPSC, v); chk("R10 empty", v, 32'h1);
    wr(A_DEC, 32'h0000_0001);
    rd(A_DEC, v); chk("R6 other bit no effect", v, 32'h0001_0000);
    wr(A_MASK, 32'h0);
    chk("R7 masked off", 32'(irq_o), 0);
    wr(A_MASK, 32'h0001_0000);
    chk("R7 unmasked", 32'(irq_o), 1);
    wr(A_DEC, 32'h0001_0000);
    rd(A_DEC, v); chk("R6 cleared", v, 0);
    chk("R7 irq after clear", 32'(irq_o), 0);

    // R8 pop on empty ignored
    wr(A_QW1, 32'h0);
    rd(A_RPSC, v); chk("R8 empty pop no nonempty", v, 32'h1);
    rd(A_QW1, v);  chk("R8 empty read", v, 0);
    send(2'd1, 1'b0, 1'b0);
    rd(A_QW1, v); chk("R8 head after empty pop", v, word_of(2'd1, 1'b0));
    drain("R8");

    // R3 overflow
    for (int i = 0; i < DEPTH + 4; i++) send(2'(i), 1'(i >> 2), 1'b0);
    rd(A_RPSC, v); chk("R3 ovf set", v, 32'h000C_0001);
    // R4 sticky
    wr(A_RPSC, 32'h1);
    rd(A_RPSC, v); chk("R4 write0 keeps", v, 32'h000C_0001);
    drain("R3 order");
    wr(A_RPSC, 32'h0008_0001);
    rd(A_RPSC, v); chk("R4 cleared", v, 32'h1);

    // R11 simultaneous at full
    for (int i = 0; i < DEPTH - 1; i++) send(2'(i + 1), 1'(i), 1'b0);
    exp_ovf = 1'b0;
    send(2'd3, 1'b1, 1'b1);
    rd(A_RPSC, v); chk("R11 drop at full", v, 32'h000C_0001);
    drain("R11 full");
    wr(A_RPSC, 32'h0008_0000);

    // R11 simultaneous at low occupancy
    for (int i = 0; i < 3; i++) send(2'(i), 1'b1, 1'b0);
    send(2'd3, 1'b0, 1'b1);
    rd(A_RPSC, v); chk("R11 no drop", v, 32'h0004_0000);
    drain("R11 both applied");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule